// File: doc/BRIEF.md
# Conversion Result Latch with Range Flags

This block sits at the end of a dual-slope style conversion pipeline. It receives the magnitude and sign of the up/down result counter, plus a strobe that is high during the closing window of every conversion cycle. When that window opens, the block captures the counter into a display register. In the same cycle it decides whether the reading is above the full-scale limit or below the low-scale limit, and it latches both range flags. An active-low status strobe follows the window so that downstream logic can tell when fresh data has landed.

A two-bit view control picks one of three modes. In the free-running mode every window updates the reading. In the freeze mode the reading and its flags are kept as they are. In the live-view mode the display tracks the running counter while the de-integrate phase is active. Outside circuitry can override each range pin through a per-bit force enable. A blank request tells the digit decoder to suppress the four low digits while the captured reading is above full scale.

Top module: `conv_result_latch`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), lat_n is 1, disp_mag is 0, disp_neg is 0, and or_pin, ur_pin and blank are 0.
- R2: lat_n goes to 0 at the first clock edge at which eoc_win is sampled high. It stays 0 while eoc_win stays high, and returns to 1 at the first edge at which eoc_win is sampled low.
- R3: In free-run mode, disp_mag and disp_neg take cnt_mag and cnt_neg as sampled at the edge where lat_n falls. Counter changes during the rest of the window do not affect them.
- R4: The overrange flag, seen on or_pin when not forced, is set by a capture whose magnitude is greater than 19999. A capture of exactly 19999 clears it.
- R5: The underrange flag, seen on ur_pin when not forced, is set by a capture whose magnitude is less than 1000. A capture of exactly 1000 clears it.
- R6: Both range flags change only at the edge where lat_n falls. Between captures they keep their values whatever the counter does.
- R7: With hold_code = 01 (freeze), a window causes no capture. disp_mag, disp_neg and both flags stay unchanged, while lat_n still follows R2.
- R8: With hold_code = 10 (live view) and deint high at a clock edge, disp_mag and disp_neg take cnt_mag and cnt_neg at that edge. The range flags still change only at captures.
- R9: With hold_code = 00 or 11 (free-run), deint has no effect on disp_mag or disp_neg.
- R10: blank equals the latched overrange flag and is unaffected by the force inputs.
- R11: Force bit 0 drives or_pin to frc_val[0] and force bit 1 drives ur_pin to frc_val[1]. Each forced pin follows its force value in the same cycle, and each unforced pin shows its latched flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_mag | input | 15 | Result counter magnitude |
| cnt_neg | input | 1 | Result counter sign, 1 = negative |
| deint | input | 1 | High while the converter is de-integrating |
| eoc_win | input | 1 | High during the closing window of a conversion cycle |
| hold_code | input | 2 | View control: 00 run, 01 freeze, 10 live, 11 run |
| frc_en | input | 2 | External override enable: bit 0 overrange pin, bit 1 underrange pin |
| frc_val | input | 2 | Value driven onto an overridden pin |
| disp_mag | output | 15 | Magnitude presented to the display decoder |
| disp_neg | output | 1 | Sign presented to the display decoder |
| or_pin | output | 1 | Overrange status, or its forced value |
| ur_pin | output | 1 | Underrange status, or its forced value |
| blank | output | 1 | Request to blank the four low digits |
| lat_n | output | 1 | Latch status strobe, low during the closing window |

## Verification
The assertions assume that eoc_win is low during reset and that each window lasts at least one cycle. They also assume that hold_code changes only between clock edges, so that a single mode governs each edge. The bench drives every input on the falling clock edge and keeps eoc_win low while reset is applied. It holds hold_code constant across each window and only changes it while eoc_win is low. It then samples on the next falling edge, one register stage after the stimulus.

// File: rtl/rl_pkg.sv
// Shared types for the conversion result latch.
// Assumes: the view control arrives as a raw 2-bit code.
package rl_pkg;
    typedef enum logic [1:0] {
        VM_RUN     = 2'b00,
        VM_FREEZE  = 2'b01,
        VM_LIVE    = 2'b10,
        VM_RUN_ALT = 2'b11
    } view_mode_e;

    // True for the codes that behave as free-running.
    function automatic logic is_run(input view_mode_e m);
        return (m == VM_RUN) || (m == VM_RUN_ALT);
    endfunction
endpackage

// File: rtl/rl_strobe.sv
// Latch status strobe generator.
// Registers the window strobe into an active-low status output and flags the
// single cycle in which the window opens (the status falling edge).
// Assumes: eoc_win is synchronous to clk and low during reset.
module rl_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_win,
    output logic lat_n,
    output logic cap
);
    // Status strobe: low one edge after the window is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_n <= 1'b1;
        else        lat_n <= ~eoc_win;
    end

    // Capture request: window seen while status is still high.
    assign cap = eoc_win & lat_n;

    a_r2_low_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_win |=> !lat_n);
    a_r2_high_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_win |=> lat_n);
endmodule

// File: rtl/rl_range_cmp.sv
// Range classifier for a candidate reading.
// Compares a magnitude against the full-scale and low-scale limits.
// Assumes: OVR_LIMIT and UNDR_LIMIT fit in MAG_W bits and UNDR_LIMIT <= OVR_LIMIT.
module rl_range_cmp #(
    parameter int MAG_W      = 15,
    parameter int OVR_LIMIT  = 19999,
    parameter int UNDR_LIMIT = 1000
) (
    input  logic [MAG_W-1:0] mag,
    output logic             over,
    output logic             under
);
    localparam logic [MAG_W-1:0] OVR_L  = OVR_LIMIT[MAG_W-1:0];
    localparam logic [MAG_W-1:0] UNDR_L = UNDR_LIMIT[MAG_W-1:0];

    // Classification of the magnitude against both limits.
    always_comb begin
        over  = (mag > OVR_L);
        under = (mag < UNDR_L);
    end
endmodule

// File: rtl/rl_view.sv
// Display and range-flag registers with the three view modes.
// Free-run captures on every window, freeze keeps everything, and live view
// also tracks the counter while de-integrating. The flags move only on captures.
// Assumes: cap is a single-cycle pulse at the status falling edge.
module rl_view
    import rl_pkg::*;
#(
    parameter int MAG_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  view_mode_e       mode,
    input  logic             cap,
    input  logic             deint,
    input  logic [MAG_W-1:0] cnt_mag,
    input  logic             cnt_neg,
    input  logic             over_in,
    input  logic             under_in,
    output logic [MAG_W-1:0] disp_mag,
    output logic             disp_neg,
    output logic             or_q,
    output logic             ur_q
);
    logic do_cap;
    logic do_live;

    // Decode when the display register loads.
    always_comb begin
        do_cap  = cap && (mode != VM_FREEZE);
        do_live = deint && (mode == VM_LIVE);
    end

    // Display register: loads on capture or live tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_mag <= '0;
            disp_neg <= 1'b0;
        end else if (do_cap || do_live) begin
            disp_mag <= cnt_mag;
            disp_neg <= cnt_neg;
        end
    end

    // Range flags: updated only at a non-frozen capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            or_q <= 1'b0;
            ur_q <= 1'b0;
        end else if (do_cap) begin
            or_q <= over_in;
            ur_q <= under_in;
        end
    end

    a_r6_flags_between_caps: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> ($stable(or_q) && $stable(ur_q)));
    a_r7_freeze_keeps_all: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == VM_FREEZE) |=> ($stable(disp_mag) && $stable(disp_neg) && $stable(or_q)));
    a_r9_run_ignores_deint: assert property (@(posedge clk) disable iff (!rst_n)
        (is_run(mode) && !cap) |=> $stable(disp_mag));
endmodule

// File: rtl/conv_result_latch.sv
// Conversion result latch with range status.
// Captures the signed result at the opening of each end-of-conversion window,
// classifies it, applies the view mode, and exposes range pins that external
// logic may override bit by bit.
// Assumes: all inputs synchronous to clk; eoc_win low during reset.
module conv_result_latch
    import rl_pkg::*;
#(
    parameter int MAG_W      = 15,
    parameter int OVR_LIMIT  = 19999,
    parameter int UNDR_LIMIT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAG_W-1:0] cnt_mag,
    input  logic             cnt_neg,
    input  logic             deint,
    input  logic             eoc_win,
    input  logic [1:0]       hold_code,
    input  logic [1:0]       frc_en,
    input  logic [1:0]       frc_val,
    output logic [MAG_W-1:0] disp_mag,
    output logic             disp_neg,
    output logic             or_pin,
    output logic             ur_pin,
    output logic             blank,
    output logic             lat_n
);
    localparam int N_FLAG = 2;

    view_mode_e        mode;
    logic              cap;
    logic              over_c;
    logic              under_c;
    logic              or_q;
    logic              ur_q;
    logic [N_FLAG-1:0] flag_q;
    logic [N_FLAG-1:0] pin_v;

    // Mode decode of the raw control code.
    assign mode = view_mode_e'(hold_code);

    rl_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .eoc_win (eoc_win),
        .lat_n   (lat_n),
        .cap     (cap)
    );

    rl_range_cmp #(
        .MAG_W      (MAG_W),
        .OVR_LIMIT  (OVR_LIMIT),
        .UNDR_LIMIT (UNDR_LIMIT)
    ) u_cmp (
        .mag   (cnt_mag),
        .over  (over_c),
        .under (under_c)
    );

    rl_view #(.MAG_W(MAG_W)) u_view (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .cap      (cap),
        .deint    (deint),
        .cnt_mag  (cnt_mag),
        .cnt_neg  (cnt_neg),
        .over_in  (over_c),
        .under_in (under_c),
        .disp_mag (disp_mag),
        .disp_neg (disp_neg),
        .or_q     (or_q),
        .ur_q     (ur_q)
    );

    assign flag_q = {ur_q, or_q};

    // Per-pin external override mux.
    for (genvar g = 0; g < N_FLAG; g++) begin : g_pin
        assign pin_v[g] = frc_en[g] ? frc_val[g] : flag_q[g];
    end

    assign or_pin = pin_v[0];
    assign ur_pin = pin_v[1];

    // Blank request follows the latched overrange, never the forced pin.
    assign blank = or_q;

    a_r4_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(or_q && ur_q));
    a_r4_or_rises_on_cap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(or_q) |-> $fell(lat_n));
    a_r11_forced_pin: assert property (@(posedge clk) disable iff (!rst_n)
        frc_en[0] |-> (or_pin == frc_val[0]));
endmodule

// File: tb/sim_conv_result_latch.sv
module sim_conv_result_latch;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] cnt_mag;
    logic        cnt_neg;
    logic        deint;
    logic        eoc_win;
    logic [1:0]  hold_code;
    logic [1:0]  frc_en;
    logic [1:0]  frc_val;
    logic [14:0] disp_mag;
    logic        disp_neg;
    logic        or_pin;
    logic        ur_pin;
    logic        blank;
    logic        lat_n;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    conv_result_latch u0 (
        .clk(clk), .rst_n(rst_n), .cnt_mag(cnt_mag), .cnt_neg(cnt_neg),
        .deint(deint), .eoc_win(eoc_win), .hold_code(hold_code),
        .frc_en(frc_en), .frc_val(frc_val), .disp_mag(disp_mag),
        .disp_neg(disp_neg), .or_pin(or_pin), .ur_pin(ur_pin),
        .blank(blank), .lat_n(lat_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // One window: counter presented at opening, then scrambled inside the window.
    task automatic run_window(input int mag, input bit neg);
        cnt_mag = 15'(mag);
        cnt_neg = neg;
        eoc_win = 1'b1;
        tick();
        chk(lat_n == 1'b0, "R2 low in window", lat_n, 0);
        cnt_mag = 15'(mag ^ 1234);
        cnt_neg = ~neg;
        tick();
        tick();
        chk(lat_n == 1'b0, "R2 still low", lat_n, 0);
        eoc_win = 1'b0;
        tick();
        chk(lat_n == 1'b1, "R2 high after window", lat_n, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cnt_mag = 15'd4321; cnt_neg = 1'b1; deint = 1'b0;
        eoc_win = 1'b0; hold_code = 2'b00; frc_en = 2'b00; frc_val = 2'b00;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk(lat_n == 1'b1, "R1 lat_n", lat_n, 1);
        chk(disp_mag == 15'd0, "R1 disp_mag", disp_mag, 0);
        chk(disp_neg == 1'b0, "R1 disp_neg", disp_neg, 0);
        chk({or_pin, ur_pin, blank} == 3'b000, "R1 flags", {or_pin, ur_pin, blank}, 0);
    endtask

    task automatic t_capture();
        run_window(12345, 1'b1);
        chk(disp_mag == 15'd12345, "R3 captured magnitude", disp_mag, 12345);
        chk(disp_neg == 1'b1, "R3 captured sign", disp_neg, 1);
        chk({or_pin, ur_pin} == 2'b00, "R4 R5 mid-scale flags", {or_pin, ur_pin}, 0);
    endtask

    task automatic t_limits();
        run_window(20000, 1'b0);
        chk(or_pin == 1'b1, "R4 20000 over", or_pin, 1);
        run_window(19999, 1'b0);
        chk(or_pin == 1'b0, "R4 19999 not over", or_pin, 0);
        run_window(999, 1'b0);
        chk(ur_pin == 1'b1, "R5 999 under", ur_pin, 1);
        run_window(1000, 1'b0);
        chk(ur_pin == 1'b0, "R5 1000 not under", ur_pin, 0);
    endtask

    task automatic t_stable();
        run_window(25000, 1'b0);
        chk(or_pin == 1'b1, "R6 over latched", or_pin, 1);
        for (int i = 0; i < 5; i++) begin
            cnt_mag = 15'(i * 3);
            tick();
        end
        chk({or_pin, ur_pin} == 2'b10, "R6 flags held between captures", {or_pin, ur_pin}, 2);
        chk(disp_mag == 15'd25000, "R6 display held", disp_mag, 25000);
    endtask

    task automatic t_hold();
        run_window(700, 1'b1);
        hold_code = 2'b01;
        tick();
        run_window(26000, 1'b0);
        chk(disp_mag == 15'd700, "R7 magnitude frozen", disp_mag, 700);
        chk(disp_neg == 1'b1, "R7 sign frozen", disp_neg, 1);
        chk({or_pin, ur_pin} == 2'b01, "R7 flags frozen", {or_pin, ur_pin}, 1);
        hold_code = 2'b00;
        tick();
    endtask

    task automatic t_live();
        run_window(500, 1'b0);
        hold_code = 2'b10;
        deint = 1'b1;
        cnt_mag = 15'd3000; cnt_neg = 1'b1;
        tick();
        chk(disp_mag == 15'd3000, "R8 live tracks", disp_mag, 3000);
        chk(disp_neg == 1'b1, "R8 live sign", disp_neg, 1);
        cnt_mag = 15'd3001;
        tick();
        chk(disp_mag == 15'd3001, "R8 live tracks next", disp_mag, 3001);
        chk(ur_pin == 1'b1, "R8 flags unchanged in live", ur_pin, 1);
        deint = 1'b0;
        cnt_mag = 15'd777;
        tick();
        chk(disp_mag == 15'd3001, "R8 stops when deint low", disp_mag, 3001);
        run_window(21000, 1'b0);
        chk(disp_mag == 15'd21000 && or_pin == 1'b1, "R8 capture in live", disp_mag, 21000);
        hold_code = 2'b00;
        tick();
    endtask

    task automatic t_run_ignores();
        for (int c = 0; c < 4; c += 3) begin
            hold_code = 2'(c);
            run_window(8000, 1'b0);
            deint = 1'b1;
            cnt_mag = 15'd4321;
            tick(); tick();
            chk(disp_mag == 15'd8000, "R9 deint ignored in run", disp_mag, 8000);
            deint = 1'b0;
        end
        hold_code = 2'b00;
        tick();
    endtask

    task automatic t_force();
        run_window(30000, 1'b0);
        chk(blank == 1'b1, "R10 blank on over", blank, 1);
        frc_en = 2'b01; frc_val = 2'b00;
        #1;
        chk(or_pin == 1'b0, "R11 or forced low", or_pin, 0);
        chk(blank == 1'b1, "R10 blank ignores force", blank, 1);
        frc_en = 2'b10; frc_val = 2'b10;
        #1;
        chk(ur_pin == 1'b1, "R11 ur forced high", ur_pin, 1);
        chk(or_pin == 1'b1, "R11 or unforced shows flag", or_pin, 1);
        frc_en = 2'b00;
        run_window(100, 1'b0);
        chk(blank == 1'b0, "R10 blank clears", blank, 0);
    endtask

    initial begin
        t_reset();
        t_capture();
        t_limits();
        t_stable();
        t_hold();
        t_live();
        t_run_ignores();
        t_force();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule